// File: doc/BRIEF.md
# Interrupt-Return Frame Unwinder

This block runs the return half of an interrupt: given the current privilege level, the operand size of the return, the live FLAGS word and the stack pointer, it walks the saved stack frame and produces the register values that execution resumes with. It fetches every frame word through a 32-bit read port with a valid/ready handshake. The port carries the address out and takes the data back in the same cycle as ready.

The first word fetched is the saved FLAGS image. Its VM bit chooses between two walks. A short walk restores EIP, CS and FLAGS and moves the stack pointer past the three words. An extended walk also restores the outer stack pointer, the stack selector and four data segment selectors. In that case every segment load is flagged as a real-style load, whose base is the selector shifted left by four.

Two conditions end a request before any stack access. A 16-bit return raises a fault. A set nested-task bit in the live FLAGS hands the return over as a task-switch request. A frame that would enter the real-style context from a nonzero privilege level raises a fault after the FLAGS fetch. Results update together, once, when a walk completes.

Top module: `irq_frame_unwinder`

## Requirements
- R1: A request with `op32_i` low raises `fault_o` for one cycle, one cycle after the request. It issues no read and leaves every result output unchanged. This check takes priority over R2.
- R2: A 32-bit request whose `flags_i` has bit 14 (nested task) set raises `task_ret_o` for one cycle, one cycle after the request. It issues no read and leaves every result output unchanged.
- R3: Otherwise the first read is at `esp_i`+8. That word becomes `flags_o`, and its bit 17 is the VM value of the resumed context.
- R4: The second read is at `esp_i`+0 and gives `eip_o`. The third is at `esp_i`+4, and only its low 16 bits give `cs_o`.
- R5: `cs_v86_o` equals the VM value. `cs_base_o` is `cs_o` shifted left by 4 when VM is 1, and 0 when VM is 0.
- R6: With VM 0 the walk ends after three reads. `esp_o` is `esp_i`+12, and `ss_o`, `es_o`, `ds_o`, `fs_o` and `gs_o` are 0.
- R7: With VM 1 six more reads follow at `esp_i`+12, +16, +20, +24, +28 and +32. In that order they give `esp_o` (full word) and then the low 16 bits of `ss_o`, `es_o`, `ds_o`, `fs_o` and `gs_o`.
- R8: With VM 1 in the image and `cpl_i` nonzero at the request, `fault_o` pulses right after the FLAGS read. No further read follows and the result outputs stay unchanged.
- R9: While `rd_valid_o` is high and `rd_ready_i` is low, the request stays valid and `rd_addr_o` holds.
- R10: `start_i` has no effect while `busy_o` is high.
- R11: A completed walk gives exactly one `done_o` pulse. All result outputs take their new values in that same cycle, and at most one of `done_o`, `fault_o` and `task_ret_o` is high at any time.
- R12: After reset, all result outputs are 0, and `busy_o` and `rd_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Return request, sampled while idle |
| op32_i | input | 1 | 1 = 32-bit operand-size return |
| cpl_i | input | 2 | Current privilege level |
| flags_i | input | 32 | Live FLAGS word |
| esp_i | input | 32 | Stack pointer at the saved EIP |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read byte address |
| rd_ready_i | input | 1 | Read accepted, data valid this cycle |
| rd_data_i | input | 32 | Read data |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk complete, results updated |
| task_ret_o | output | 1 | Task-switch return requested |
| fault_o | output | 1 | Request refused |
| eip_o | output | 32 | Restored EIP |
| cs_o | output | 16 | Restored CS selector |
| cs_v86_o | output | 1 | Segment loads are real-style |
| cs_base_o | output | 32 | Base for the CS load |
| flags_o | output | 32 | Restored FLAGS |
| esp_o | output | 32 | Restored stack pointer |
| ss_o | output | 16 | Restored SS selector |
| es_o | output | 16 | Restored ES selector |
| ds_o | output | 16 | Restored DS selector |
| fs_o | output | 16 | Restored FS selector |
| gs_o | output | 16 | Restored GS selector |

## Verification
The hardest case to reach is a new request that arrives during an extended walk while reads are being stalled. It must leave both the address sequence and the results untouched. The bench drives a pseudo-random ready pattern and raises `start_i` with a different stack pointer a few cycles into a VM=1 walk. It then checks every later read address against the queue of addresses the model predicts. The privilege fault that occurs in the middle of a walk is reached with a frame whose FLAGS image carries VM=1 at a nonzero level. That run must leave exactly one read, and then no read, behind it.

// File: rtl/unw_pkg.sv
package unw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_READ   = 2'd1,
      ST_COMMIT = 2'd2
   } unw_state_e;

   // Byte offset from the entry stack pointer for each read step.
   // Step 0 fetches the FLAGS image, steps 1..2 the code pointer,
   // steps 3.. the outer frame that lies past the FLAGS image.
   function automatic int step_offset(input int k, input int stride);
      if (k == 0)
         return 2 * stride;
      else if (k < 3)
         return (k - 1) * stride;
      else
         return k * stride;
   endfunction

endpackage

// File: rtl/unw_addr_gen.sv
module unw_addr_gen
   import unw_pkg::*;
#(
   parameter int AW     = 32,
   parameter int STRIDE = 4,
   parameter int SW     = 4
) (
   input  logic [AW-1:0] base_i,
   input  logic [SW-1:0] step_i,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] offset;

   always_comb begin
      offset = AW'(step_offset(32'(step_i), STRIDE));
      addr_o = base_i + offset;
   end

endmodule

// File: rtl/unw_seg_base.sv
module unw_seg_base #(
   parameter int AW    = 32,
   parameter int SELW  = 16,
   parameter int SHIFT = 4
) (
   input  logic [SELW-1:0] sel_i,
   input  logic            v86_i,
   output logic [AW-1:0]   base_o
);

   generate
      if (SHIFT == 0) begin : g_flat
         assign base_o = v86_i ? AW'(sel_i) : '0;
      end else begin : g_shift
         assign base_o = v86_i ? (AW'(sel_i) << SHIFT) : '0;
      end
   endgenerate

endmodule

// File: rtl/unw_ctrl.sv
module unw_ctrl
   import unw_pkg::*;
#(
   parameter int NSTEP      = 9,
   parameter int SHORT_LAST = 2,
   parameter int SW         = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic          op32_i,
   input  logic          nt_i,
   input  logic          cpl_nz_i,
   input  logic          rd_ready_i,
   input  logic          vm_img_i,
   input  logic          vm_lat_i,
   output logic          busy_o,
   output logic          rd_valid_o,
   output logic          accept_o,
   output logic          hs_o,
   output logic          commit_o,
   output logic          done_o,
   output logic          fault_o,
   output logic          task_o,
   output logic [SW-1:0] step_o
);

   localparam logic [SW-1:0] LAST_EXT   = SW'(NSTEP - 1);
   localparam logic [SW-1:0] LAST_SHORT = SW'(SHORT_LAST);

   unw_state_e    st;
   logic [SW-1:0] step_q;
   logic          cpl_nz_q;

   assign busy_o     = (st != ST_IDLE);
   assign rd_valid_o = (st == ST_READ);
   assign hs_o       = rd_valid_o & rd_ready_i;
   assign accept_o   = (st == ST_IDLE) & start_i & op32_i & ~nt_i;
   assign commit_o   = (st == ST_COMMIT);
   assign step_o     = step_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st       <= ST_IDLE;
         step_q   <= '0;
         cpl_nz_q <= 1'b0;
         done_o   <= 1'b0;
         fault_o  <= 1'b0;
         task_o   <= 1'b0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         task_o  <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  if (!op32_i) begin
                     fault_o <= 1'b1;
                  end else if (nt_i) begin
                     task_o <= 1'b1;
                  end else begin
                     st       <= ST_READ;
                     step_q   <= '0;
                     cpl_nz_q <= cpl_nz_i;
                  end
               end
            end
            ST_READ: begin
               if (rd_ready_i) begin
                  if (step_q == '0 && vm_img_i && cpl_nz_q) begin
                     fault_o <= 1'b1;
                     st      <= ST_IDLE;
                  end else if (step_q == LAST_EXT ||
                               (step_q == LAST_SHORT && !vm_lat_i)) begin
                     st <= ST_COMMIT;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_COMMIT: begin
               done_o <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/irq_frame_unwinder.sv
module irq_frame_unwinder #(
   parameter int AW         = 32,
   parameter int SELW       = 16,
   parameter int CPLW       = 2,
   parameter int VM_BIT     = 17,
   parameter int NT_BIT     = 14,
   parameter int STRIDE     = 4,
   parameter int REAL_SHIFT = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic            op32_i,
   input  logic [CPLW-1:0] cpl_i,
   input  logic [AW-1:0]   flags_i,
   input  logic [AW-1:0]   esp_i,
   output logic            rd_valid_o,
   output logic [AW-1:0]   rd_addr_o,
   input  logic            rd_ready_i,
   input  logic [AW-1:0]   rd_data_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            task_ret_o,
   output logic            fault_o,
   output logic [AW-1:0]   eip_o,
   output logic [SELW-1:0] cs_o,
   output logic            cs_v86_o,
   output logic [AW-1:0]   cs_base_o,
   output logic [AW-1:0]   flags_o,
   output logic [AW-1:0]   esp_o,
   output logic [SELW-1:0] ss_o,
   output logic [SELW-1:0] es_o,
   output logic [SELW-1:0] ds_o,
   output logic [SELW-1:0] fs_o,
   output logic [SELW-1:0] gs_o
);

   localparam int NSTEP      = 9;
   localparam int SHORT_LAST = 2;
   localparam int SW         = $clog2(NSTEP);
   localparam int NSEG       = 4;
   localparam int SEG_FIRST  = 5;
   localparam int IDX_FLAGS  = 0;
   localparam int IDX_EIP    = 1;
   localparam int IDX_CS     = 2;
   localparam int IDX_OESP   = 3;
   localparam int IDX_OSS    = 4;
   localparam logic [AW-1:0] SHORT_POP = AW'(3 * STRIDE);

   generate
      if (VM_BIT >= AW || NT_BIT >= AW) begin : g_bad_bit
         $error("flag bit positions must lie inside the data word");
      end
      if (SELW + REAL_SHIFT > AW || SELW > AW) begin : g_bad_sel
         $error("selector plus shift must fit the address width");
      end
      if (STRIDE < 1 || CPLW < 1) begin : g_bad_misc
         $error("stride and privilege width must be positive");
      end
   endgenerate

   logic          accept, hs, commit;
   logic [SW-1:0] step;
   logic [AW-1:0] base_q;
   logic [AW-1:0] sh [NSTEP];
   logic          vm;
   logic [AW-1:0] cs_base_c;

   assign vm = sh[IDX_FLAGS][VM_BIT];

   unw_ctrl #(
      .NSTEP      (NSTEP),
      .SHORT_LAST (SHORT_LAST),
      .SW         (SW)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .op32_i     (op32_i),
      .nt_i       (flags_i[NT_BIT]),
      .cpl_nz_i   (|cpl_i),
      .rd_ready_i (rd_ready_i),
      .vm_img_i   (rd_data_i[VM_BIT]),
      .vm_lat_i   (vm),
      .busy_o     (busy_o),
      .rd_valid_o (rd_valid_o),
      .accept_o   (accept),
      .hs_o       (hs),
      .commit_o   (commit),
      .done_o     (done_o),
      .fault_o    (fault_o),
      .task_o     (task_ret_o),
      .step_o     (step)
   );

   unw_addr_gen #(
      .AW     (AW),
      .STRIDE (STRIDE),
      .SW     (SW)
   ) u_addr (
      .base_i (base_q),
      .step_i (step),
      .addr_o (rd_addr_o)
   );

   unw_seg_base #(
      .AW    (AW),
      .SELW  (SELW),
      .SHIFT (REAL_SHIFT)
   ) u_csbase (
      .sel_i  (sh[IDX_CS][SELW-1:0]),
      .v86_i  (vm),
      .base_o (cs_base_c)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         base_q <= '0;
      else if (accept)
         base_q <= esp_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < NSTEP; k++) sh[k] <= '0;
      end else if (hs) begin
         for (int k = 0; k < NSTEP; k++)
            if (step == SW'(k)) sh[k] <= rd_data_i;
      end
   end

   logic [SELW-1:0] seg_nxt [NSEG];
   logic [SELW-1:0] seg_q   [NSEG];

   generate
      for (genvar i = 0; i < NSEG; i++) begin : g_seg
         assign seg_nxt[i] = vm ? sh[SEG_FIRST+i][SELW-1:0] : '0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         eip_o     <= '0;
         cs_o      <= '0;
         cs_v86_o  <= 1'b0;
         cs_base_o <= '0;
         flags_o   <= '0;
         esp_o     <= '0;
         ss_o      <= '0;
         for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
      end else if (commit) begin
         flags_o   <= sh[IDX_FLAGS];
         eip_o     <= sh[IDX_EIP];
         cs_o      <= sh[IDX_CS][SELW-1:0];
         cs_v86_o  <= vm;
         cs_base_o <= cs_base_c;
         esp_o     <= vm ? sh[IDX_OESP] : base_q + SHORT_POP;
         ss_o      <= vm ? sh[IDX_OSS][SELW-1:0] : '0;
         for (int i = 0; i < NSEG; i++) seg_q[i] <= seg_nxt[i];
      end
   end

   assign es_o = seg_q[0];
   assign ds_o = seg_q[1];
   assign fs_o = seg_q[2];
   assign gs_o = seg_q[3];

endmodule

// File: rtl/unw_chk.sv
module unw_chk #(
   parameter int AW         = 32,
   parameter int SELW       = 16,
   parameter int NT_BIT     = 14,
   parameter int STRIDE     = 4,
   parameter int REAL_SHIFT = 4
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            start_i,
   input logic            op32_i,
   input logic [AW-1:0]   flags_i,
   input logic [AW-1:0]   esp_i,
   input logic            rd_valid_o,
   input logic [AW-1:0]   rd_addr_o,
   input logic            rd_ready_i,
   input logic            busy_o,
   input logic            done_o,
   input logic            task_ret_o,
   input logic            fault_o,
   input logic [SELW-1:0] cs_o,
   input logic            cs_v86_o,
   input logic [AW-1:0]   cs_base_o
);

   AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R9

   AST_ONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({done_o, fault_o, task_ret_o})); // R11

   AST_FIRST_IMAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> rd_valid_o && rd_addr_o == $past(esp_i) + AW'(2 * STRIDE)); // R3

   AST_NARROW_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !busy_o && !op32_i |=> fault_o && !busy_o); // R1

   AST_NESTED_TASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !busy_o && op32_i && flags_i[NT_BIT] |=> task_ret_o && !busy_o); // R2

   AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> !busy_o && !rd_valid_o); // R8

   AST_CS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> cs_base_o == (cs_v86_o ? (AW'(cs_o) << REAL_SHIFT) : AW'(0))); // R5

endmodule

bind irq_frame_unwinder unw_chk #(
   .AW         (AW),
   .SELW       (SELW),
   .NT_BIT     (NT_BIT),
   .STRIDE     (STRIDE),
   .REAL_SHIFT (REAL_SHIFT)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .op32_i     (op32_i),
   .flags_i    (flags_i),
   .esp_i      (esp_i),
   .rd_valid_o (rd_valid_o),
   .rd_addr_o  (rd_addr_o),
   .rd_ready_i (rd_ready_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .task_ret_o (task_ret_o),
   .fault_o    (fault_o),
   .cs_o       (cs_o),
   .cs_v86_o   (cs_v86_o),
   .cs_base_o  (cs_base_o)
);

// File: tb/irq_frame_unwinder_tb.sv
`timescale 1ns/1ps
module irq_frame_unwinder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op32 = 1'b1;
   logic [1:0]  cpl = 2'd0;
   logic [31:0] flags = 32'h2;
   logic [31:0] esp = 32'h0;
   logic        rd_valid, rd_ready;
   logic [31:0] rd_addr, rd_data;
   logic        busy, done, task_ret, fault, cs_v86;
   logic [31:0] eip, cs_base, flags_r, esp_r;
   logic [15:0] cs, ss, es, ds, fs, gs;

   logic [31:0] mem [64];
   logic        stall_en = 1'b0;
   logic [7:0]  lfsr = 8'h5B;

   int nchk = 0;
   int nfail = 0;
   bit finished = 0;

   logic [31:0] exp_q[$];
   logic [31:0] e_eip = 0, e_flags = 0, e_esp = 0, e_base = 0;
   logic [15:0] e_cs = 0, e_ss = 0, e_es = 0, e_ds = 0, e_fs = 0, e_gs = 0;
   logic        e_v86 = 0;

   always #4 clk = ~clk;

   assign rd_data = mem[rd_addr[7:2]];

   irq_frame_unwinder u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op32_i(op32), .cpl_i(cpl),
      .flags_i(flags), .esp_i(esp), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr),
      .rd_ready_i(rd_ready), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
      .task_ret_o(task_ret), .fault_o(fault), .eip_o(eip), .cs_o(cs),
      .cs_v86_o(cs_v86), .cs_base_o(cs_base), .flags_o(flags_r), .esp_o(esp_r),
      .ss_o(ss), .es_o(es), .ds_o(ds), .fs_o(fs), .gs_o(gs)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // ready pattern, updated away from the sampling edge
   initial begin
      rd_ready = 1'b1;
      forever begin
         @(posedge clk);
         #1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         rd_ready = stall_en ? (lfsr[0] & lfsr[2]) | lfsr[5] : 1'b1;
      end
   end

   // per-clock reference comparison of the read port
   logic        pv = 0, pr = 0;
   logic [31:0] pa = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pv && !pr) begin
            check(rd_valid == 1'b1, "R9", "valid dropped under stall", 32'(rd_valid), 32'd1);
            check(rd_addr == pa, "R9", "address moved under stall", rd_addr, pa);
         end
         if (rd_valid && rd_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "unexpected read", rd_addr, 32'hFFFF_FFFF);
            end else begin
               logic [31:0] a;
               a = exp_q.pop_front();
               check(rd_addr == a, "R7", "read address order", rd_addr, a);
            end
         end
      end
      pv = rd_valid;
      pr = rd_ready;
      pa = rd_addr;
   end

   task automatic check_outputs(input string req);
      check(eip == e_eip, req, "eip", eip, e_eip);
      check(cs == e_cs, req, "cs", 32'(cs), 32'(e_cs));
      check(cs_v86 == e_v86, req, "cs_v86", 32'(cs_v86), 32'(e_v86));
      check(cs_base == e_base, req, "cs_base", cs_base, e_base);
      check(flags_r == e_flags, req, "flags", flags_r, e_flags);
      check(esp_r == e_esp, req, "esp", esp_r, e_esp);
      check(ss == e_ss, req, "ss", 32'(ss), 32'(e_ss));
      check({es, ds} == {e_es, e_ds}, req, "es:ds", {es, ds}, {e_es, e_ds});
      check({fs, gs} == {e_fs, e_gs}, req, "fs:gs", {fs, gs}, {e_fs, e_gs});
   endtask

   // w[0]=FLAGS image, w[1]=EIP, w[2]=CS word, w[3..8]=outer ESP, SS, ES, DS, FS, GS
   task automatic run(input logic [31:0] sp, input logic [1:0] lvl, input logic wide,
                      input logic [31:0] live_flags, input logic [31:0] w [9],
                      input bit stall, input bit poke, input string tag);
      int kind; // 0 done, 1 fault, 2 task
      logic vm;
      bit got;
      for (int k = 0; k < 9; k++) begin
         logic [31:0] a;
         a = sp + 32'(unw_off(k));
         mem[a[7:2]] = w[k];
      end
      vm = w[0][17];
      if (!wide) kind = 1;
      else if (live_flags[14]) kind = 2;
      else if (vm && lvl != 0) begin kind = 1; exp_q.push_back(sp + 32'd8); end
      else begin
         kind = 0;
         exp_q.push_back(sp + 32'd8);
         exp_q.push_back(sp);
         exp_q.push_back(sp + 32'd4);
         if (vm) for (int k = 3; k < 9; k++) exp_q.push_back(sp + 32'(4 * k));
         e_flags = w[0];
         e_eip = w[1];
         e_cs = w[2][15:0];
         e_v86 = vm;
         e_base = vm ? {12'h0, w[2][15:0], 4'h0} : 32'h0;
         e_esp = vm ? w[3] : sp + 32'd12;
         e_ss = vm ? w[4][15:0] : 16'h0;
         e_es = vm ? w[5][15:0] : 16'h0;
         e_ds = vm ? w[6][15:0] : 16'h0;
         e_fs = vm ? w[7][15:0] : 16'h0;
         e_gs = vm ? w[8][15:0] : 16'h0;
      end
      stall_en = stall;
      @(posedge clk);
      #1;
      esp = sp; cpl = lvl; op32 = wide; flags = live_flags; start = 1'b1;
      @(posedge clk);
      #1;
      start = 1'b0;
      got = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (done | fault | task_ret) begin got = 1; break; end
         if (poke && i == 2) begin
            check(busy == 1'b1, "R10", {tag, " busy at poke"}, 32'(busy), 32'd1);
            start = 1'b1; esp = 32'h0000_3000; flags = 32'h0000_4002;
         end
         if (poke && i == 3) begin
            start = 1'b0; esp = sp; flags = live_flags;
         end
      end
      check(got, "R11", {tag, " completion seen"}, 32'(got), 32'd1);
      case (kind)
         0: check({done, fault, task_ret} == 3'b100, "R11", {tag, " done pulse"},
                  32'({done, fault, task_ret}), 32'b100);
         1: check({done, fault, task_ret} == 3'b010, wide ? "R8" : "R1", {tag, " fault pulse"},
                  32'({done, fault, task_ret}), 32'b010);
         default: check({done, fault, task_ret} == 3'b001, "R2", {tag, " task pulse"},
                  32'({done, fault, task_ret}), 32'b001);
      endcase
      check(exp_q.size() == 0, "R7", {tag, " reads outstanding"}, 32'(exp_q.size()), 32'd0);
      check_outputs(kind == 0 ? (vm ? "R7" : "R6") : (kind == 2 ? "R2" : (wide ? "R8" : "R1")));
      repeat (4) @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R11", {tag, " single pulse"}, 32'({done, busy}), 32'd0);
      exp_q.delete();
   endtask

   function automatic int unw_off(input int k);
      if (k == 0) return 8;
      else if (k < 3) return (k - 1) * 4;
      else return k * 4;
   endfunction

   function automatic void mkframe(output logic [31:0] w [9], input logic [31:0] img, input int seed);
      for (int k = 0; k < 9; k++) w[k] = 32'hA500_0000 + 32'(seed << 8) + 32'(k * 16'h1111);
      w[0] = img;
   endfunction

   initial begin
      logic [31:0] w [9];
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      check(busy == 1'b0 && rd_valid == 1'b0, "R12", "idle after reset", 32'({busy, rd_valid}), 32'd0);
      check_outputs("R12");

      // R3 R4 R6: short unwind, free-flowing port
      mkframe(w, 32'h0000_0246, 1);
      run(32'h0000_1040, 2'd3, 1'b1, 32'h2, w, 0, 0, "short");

      // R5 R7: extended unwind with stalls, upper CS bits discarded
      mkframe(w, 32'h0002_0202, 2);
      w[2] = 32'hABCD_1234;
      run(32'h0000_2080, 2'd0, 1'b1, 32'h2, w, 1, 0, "extended");

      // R2: nested-task return leaves outputs untouched
      mkframe(w, 32'h0000_0202, 3);
      run(32'h0000_1040, 2'd0, 1'b1, 32'h0000_4002, w, 0, 0, "nested");

      // R1: 16-bit return refused
      mkframe(w, 32'h0000_0202, 4);
      run(32'h0000_1040, 2'd0, 1'b0, 32'h2, w, 0, 0, "narrow");

      // R1 over R2 priority
      run(32'h0000_1040, 2'd0, 1'b0, 32'h0000_4002, w, 0, 0, "narrow+nested");

      // R8: VM image at privilege 2
      mkframe(w, 32'h0002_0002, 5);
      run(32'h0000_30C0, 2'd2, 1'b1, 32'h2, w, 1, 0, "priv");

      // R6: short unwind with stalls at level 0
      mkframe(w, 32'h0000_0893, 6);
      run(32'h0000_30C0, 2'd0, 1'b1, 32'h2, w, 1, 0, "short-stall");

      // R10: request while busy is ignored
      mkframe(w, 32'h0002_0046, 7);
      w[2] = 32'h0000_FFFF;
      run(32'h0000_2080, 2'd0, 1'b1, 32'h2, w, 1, 1, "poke");

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         check(1'b0, "R11", "watchdog expired", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule